// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor whose calls and returns move a window over a ring of register frames. The core addresses 32 architectural registers through a 5-bit number. Eight of them are global and belong to no window. The other 24 are seen through the current window: eight outgoing, eight local and eight incoming. Adjacent windows share one group of eight, so a callee's incoming registers are the same physical storage as its caller's outgoing registers. The window count `NWIN` is a parameter from 2 to 32, and the physical array holds `8 + 16*NWIN` words.

A save moves the current-window pointer one step down the ring and a restore moves it one step up. One frame is always marked invalid. When a save or restore would enter that frame, the pointer stays where it is and a one-cycle trap pulse is raised instead. A trap handler then uses a sideband port to move exactly one frame to memory (spill) or from memory (fill), and signals completion. The invalid mark then shifts by one frame, so the retried operation succeeds. Per-direction trap counters let software measure how often a save or restore misses the register file.

Top module: `regwin_file`

## Requirements
- R1: After a synchronous reset the pointer is 0, the invalid mask is one-hot at bit 1, the resident-window count is 1, both trap outputs are low, both trap counters are 0 and all read data outputs are 0.
- R2: Registers 1 to 7 are shared by every window. Within window w, registers 16 to 23 are private, and registers 24 to 31 are the same storage that window w+1 (modulo NWIN) sees as registers 8 to 15. So after a save, register 24+k returns what register 8+k held before it.
- R3: Register 0 reads as zero on both read ports, and a write to register 0 changes nothing.
- R4: Read data appears one clock after the address is presented. If the register being read is written in the same cycle, the new value is returned.
- R5: A non-trapping save sets the pointer to pointer-1 modulo NWIN and raises the resident count by one. A non-trapping restore sets it to pointer+1 modulo NWIN and lowers the count by one.
- R6: A save whose target frame is the invalid one leaves the pointer and the count unchanged, pulses the overflow trap output high for one cycle and adds one to the overflow counter.
- R7: A restore whose target frame is the invalid one leaves the pointer and the count unchanged, pulses the underflow trap output for one cycle and adds one to the underflow counter.
- R8: When save and restore are asserted together, the save is performed and the restore is ignored.
- R9: A sideband read (enable high, write low) with index i returns, one cycle later, register 16+i of the frame just below the invalid one (invalid index-1 modulo NWIN). A spill-done pulse moves the invalid mark down by one frame and lowers the count by one. The pulse is ignored if the mark would then land on the current window, or if fill-done is asserted in the same cycle.
- R10: A fill-done pulse moves the invalid mark up by one frame and raises the count by one. It is ignored if the mark would then land on the current window, or if spill-done is asserted in the same cycle.
- R11: A sideband write (enable and write high) with index i stores into register 16+i of the invalid frame. When it coincides with a core write, the core write is dropped.
- R12: The sideband read data holds its last value in cycles without a sideband read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Architectural register for read port A |
| rd_a_data | output | XLEN | Registered read data, port A |
| rd_b_addr | input | 5 | Architectural register for read port B |
| rd_b_data | output | XLEN | Registered read data, port B |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | 5 | Architectural register for the core write |
| wr_data | input | XLEN | Core write data |
| save | input | 1 | Save strobe (move to a new window) |
| restore | input | 1 | Restore strobe (return to the previous window) |
| ovf_trap | output | 1 | One-cycle overflow trap pulse |
| unf_trap | output | 1 | One-cycle underflow trap pulse |
| cwp | output | $clog2(NWIN) | Current-window pointer |
| wim | output | NWIN | One-hot invalid-frame mask |
| active | output | $clog2(NWIN) | Count of resident windows |
| ovf_count | output | CNT_W | Overflow trap counter |
| unf_count | output | CNT_W | Underflow trap counter |
| sb_en | input | 1 | Sideband access strobe |
| sb_we | input | 1 | Sideband direction: 1 fills the invalid frame, 0 reads the spill frame |
| sb_idx | input | 4 | Frame slot: 0-7 locals, 8-15 incoming |
| sb_wdata | input | XLEN | Sideband fill data |
| sb_rdata | output | XLEN | Registered sideband spill data |
| spill_done | input | 1 | Spill of one frame finished |
| fill_done | input | 1 | Fill of one frame finished |

## Verification
The hardest case to reach from the ports is the full trap round trip. The ring has to be filled until a save hits the invalid frame, then the frame below it is spilled, then enough restores are made to hit the mark from the other side, and the frame is filled back. The bench gets there with a directed sequence: six saves from reset, a sixteen-slot sideband read, spill-done, one more save, seven restores, a sixteen-slot sideband write and fill-done. It then checks that the data spilled and filled back is visible again through the core's window. The refusals of spill-done and fill-done at both ends of the resident range are reached on the same path. A long random stream then mixes every strobe against the behavioural model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int ARCH_W     = 5;
  localparam int GLOBAL_N   = 8;
  localparam int GROUP_N    = 8;
  localparam int FRAME_N    = 2 * GROUP_N;
  localparam int SB_IDX_W   = 4;

  // Indices of the address mappers instantiated by the top module.
  typedef enum int {
    MAP_RD_A = 0,
    MAP_RD_B = 1,
    MAP_WR   = 2,
    MAP_SB   = 3
  } map_port_e;

  localparam int MAP_PORTS = 4;

  // Step one frame down the ring.
  function automatic int ring_prev(int w, int n);
    return (w == 0) ? n - 1 : w - 1;
  endfunction

  // Physical slot of architectural register r in window w of an n-window ring.
  // Window w owns slots 8+16w .. 8+16w+15 (outgoing then locals); its incoming
  // group is the next window's outgoing group.
  function automatic int phys_slot(int w, int r, int n);
    int off;
    if (r < GLOBAL_N) return r;
    off = w * FRAME_N + (r - GLOBAL_N);
    if (off >= n * FRAME_N) off = off - n * FRAME_N;
    return GLOBAL_N + off;
  endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [CW-1:0] win_i,
  input  logic [4:0]    arch_i,
  output logic [PW-1:0] phys_o
);

  assign phys_o = PW'(regwin_pkg::phys_slot(int'(win_i), int'(arch_i), NWIN));

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [PW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            ren_i   [NRD],
  input  logic [PW-1:0]   raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);

  logic [XLEN-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata_o[p] <= '0;
      end else if (ren_i[p]) begin
        if (raddr_i[p] == '0)
          rdata_o[p] <= '0;
        else if (we_i && (waddr_i == raddr_i[p]))
          rdata_o[p] <= wdata_i;
        else
          rdata_o[p] <= mem[raddr_i[p]];
      end
    end
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN  = 8,
  parameter int CW    = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             spill_done_i,
  input  logic             fill_done_i,
  output logic [CW-1:0]    cwp_o,
  output logic [CW-1:0]    wim_idx_o,
  output logic [NWIN-1:0]  wim_mask_o,
  output logic [CW-1:0]    active_o,
  output logic             ovf_trap_o,
  output logic             unf_trap_o,
  output logic [CNT_W-1:0] ovf_cnt_o,
  output logic [CNT_W-1:0] unf_cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  function automatic logic [CW-1:0] step_dn(input logic [CW-1:0] w);
    return (w == '0) ? LAST : w - CW'(1);
  endfunction

  function automatic logic [CW-1:0] step_up(input logic [CW-1:0] w);
    return (w == LAST) ? '0 : w + CW'(1);
  endfunction

  logic [CW-1:0] cwp_q, wim_q, act_q;
  logic [CW-1:0] cwp_n, wim_n, act_n;
  logic          do_save, do_rest, hit_ovf, hit_unf;
  logic          spill_ok, fill_ok;

  always_comb begin
    hit_ovf = save_i && (step_dn(cwp_q) == wim_q);
    do_save = save_i && !hit_ovf;
    hit_unf = !save_i && restore_i && (step_up(cwp_q) == wim_q);
    do_rest = !save_i && restore_i && !hit_unf;

    cwp_n = cwp_q;
    if (do_save)      cwp_n = step_dn(cwp_q);
    else if (do_rest) cwp_n = step_up(cwp_q);

    spill_ok = spill_done_i && !fill_done_i && (step_dn(wim_q) != cwp_n);
    fill_ok  = fill_done_i && !spill_done_i && (step_up(wim_q) != cwp_n);

    wim_n = wim_q;
    if (spill_ok)     wim_n = step_dn(wim_q);
    else if (fill_ok) wim_n = step_up(wim_q);

    act_n = act_q;
    if (do_save)  act_n = act_n + CW'(1);
    if (do_rest)  act_n = act_n - CW'(1);
    if (spill_ok) act_n = act_n - CW'(1);
    if (fill_ok)  act_n = act_n + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q      <= '0;
      wim_q      <= CW'(1);
      wim_mask_o <= NWIN'(2);
      act_q      <= CW'(1);
      ovf_trap_o <= 1'b0;
      unf_trap_o <= 1'b0;
      ovf_cnt_o  <= '0;
      unf_cnt_o  <= '0;
    end else begin
      cwp_q      <= cwp_n;
      wim_q      <= wim_n;
      wim_mask_o <= NWIN'(1) << wim_n;
      act_q      <= act_n;
      ovf_trap_o <= hit_ovf;
      unf_trap_o <= hit_unf;
      if (hit_ovf) ovf_cnt_o <= ovf_cnt_o + CNT_W'(1);
      if (hit_unf) unf_cnt_o <= unf_cnt_o + CNT_W'(1);
    end
  end

  assign cwp_o     = cwp_q;
  assign wim_idx_o = wim_q;
  assign active_o  = act_q;

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN  = 8,
  parameter int XLEN  = 32,
  parameter int CNT_W = 16,
  localparam int CW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       rd_a_addr,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [4:0]       rd_b_addr,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             save,
  input  logic             restore,
  output logic             ovf_trap,
  output logic             unf_trap,
  output logic [CW-1:0]    cwp,
  output logic [NWIN-1:0]  wim,
  output logic [CW-1:0]    active,
  output logic [CNT_W-1:0] ovf_count,
  output logic [CNT_W-1:0] unf_count,
  input  logic             sb_en,
  input  logic             sb_we,
  input  logic [3:0]       sb_idx,
  input  logic [XLEN-1:0]  sb_wdata,
  output logic [XLEN-1:0]  sb_rdata,
  input  logic             spill_done,
  input  logic             fill_done
);

  import regwin_pkg::*;

  localparam int NPHYS = GLOBAL_N + FRAME_N * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 3;

  logic [CW-1:0] wim_idx;
  logic [CW-1:0] sb_win;

  regwin_ctrl #(.NWIN(NWIN), .CW(CW), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .save_i       (save),
    .restore_i    (restore),
    .spill_done_i (spill_done),
    .fill_done_i  (fill_done),
    .cwp_o        (cwp),
    .wim_idx_o    (wim_idx),
    .wim_mask_o   (wim),
    .active_o     (active),
    .ovf_trap_o   (ovf_trap),
    .unf_trap_o   (unf_trap),
    .ovf_cnt_o    (ovf_count),
    .unf_cnt_o    (unf_count)
  );

  // Fill targets the invalid frame itself; spill reads the frame below it.
  assign sb_win = sb_we ? wim_idx : CW'(ring_prev(int'(wim_idx), NWIN));

  logic [CW-1:0] m_win  [MAP_PORTS];
  logic [4:0]    m_arch [MAP_PORTS];
  logic [PW-1:0] m_phys [MAP_PORTS];

  assign m_win[MAP_RD_A]  = cwp;
  assign m_arch[MAP_RD_A] = rd_a_addr;
  assign m_win[MAP_RD_B]  = cwp;
  assign m_arch[MAP_RD_B] = rd_b_addr;
  assign m_win[MAP_WR]    = cwp;
  assign m_arch[MAP_WR]   = wr_addr;
  assign m_win[MAP_SB]    = sb_win;
  assign m_arch[MAP_SB]   = {1'b1, sb_idx};

  for (genvar p = 0; p < MAP_PORTS; p++) begin : g_map
    regwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .win_i  (m_win[p]),
      .arch_i (m_arch[p]),
      .phys_o (m_phys[p])
    );
  end

  logic            sb_wr, st_we;
  logic [PW-1:0]   st_waddr;
  logic [XLEN-1:0] st_wdata;
  logic            st_ren   [NRD];
  logic [PW-1:0]   st_raddr [NRD];
  logic [XLEN-1:0] st_rdata [NRD];

  assign sb_wr    = sb_en && sb_we;
  assign st_we    = sb_wr || (wr_en && (wr_addr != 5'd0));
  assign st_waddr = sb_wr ? m_phys[MAP_SB] : m_phys[MAP_WR];
  assign st_wdata = sb_wr ? sb_wdata : wr_data;

  assign st_ren[0]   = 1'b1;
  assign st_raddr[0] = m_phys[MAP_RD_A];
  assign st_ren[1]   = 1'b1;
  assign st_raddr[1] = m_phys[MAP_RD_B];
  assign st_ren[2]   = sb_en && !sb_we;
  assign st_raddr[2] = m_phys[MAP_SB];

  regwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we_i    (st_we),
    .waddr_i (st_waddr),
    .wdata_i (st_wdata),
    .ren_i   (st_ren),
    .raddr_i (st_raddr),
    .rdata_o (st_rdata)
  );

  assign rd_a_data = st_rdata[0];
  assign rd_b_data = st_rdata[1];
  assign sb_rdata  = st_rdata[2];

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN  = 8,
  parameter int XLEN  = 32,
  parameter int CNT_W = 16,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       rd_a_addr,
  input logic [XLEN-1:0]  rd_a_data,
  input logic             save,
  input logic             ovf_trap,
  input logic             unf_trap,
  input logic [CW-1:0]    cwp,
  input logic [NWIN-1:0]  wim,
  input logic [CW-1:0]    active,
  input logic [CNT_W-1:0] ovf_count,
  input logic [CNT_W-1:0] unf_count
);

  int widx;
  always_comb begin
    widx = 0;
    for (int i = 0; i < NWIN; i++) if (wim[i]) widx = i;
  end

  function automatic int down_one(int w);
    return (w == 0) ? NWIN - 1 : w - 1;
  endfunction

  p_trap_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ovf_trap && unf_trap));

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> (cwp == $past(cwp)) && (active == $past(active)) &&
                 (ovf_count == $past(ovf_count) + CNT_W'(1)));

  p_unf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    unf_trap |-> (cwp == $past(cwp)) && (active == $past(active)) &&
                 (unf_count == $past(unf_count) + CNT_W'(1)));

  p_wim_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(wim) == 1);

  p_cwp_valid_r5: assert property (@(posedge clk) disable iff (rst)
    wim[cwp] == 1'b0);

  p_active_span_r10: assert property (@(posedge clk) disable iff (rst)
    int'(active) == ((widx - int'(cwp) + NWIN) % NWIN));

  p_save_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(save) && !ovf_trap) |->
      (int'(cwp) == down_one(int'($past(cwp)))));

  p_r0_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_a_addr) == 5'd0)) |-> (rd_a_data == '0));

endmodule

bind regwin_file regwin_file_chk #(
  .NWIN(NWIN), .XLEN(XLEN), .CNT_W(CNT_W), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .save      (save),
  .ovf_trap  (ovf_trap),
  .unf_trap  (unf_trap),
  .cwp       (cwp),
  .wim       (wim),
  .active    (active),
  .ovf_count (ovf_count),
  .unf_count (unf_count)
);

// File: tb/tb_regwin_file.sv
module tb_regwin_file;
  localparam int NW    = 8;
  localparam int XL    = 32;
  localparam int CN    = 16;
  localparam int CWB   = 3;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [XL-1:0] rd_a_data, rd_b_data, wr_data, sb_wdata, sb_rdata;
  logic wr_en, save, restore, sb_en, sb_we, spill_done, fill_done;
  logic [3:0] sb_idx;
  logic ovf_trap, unf_trap;
  logic [CWB-1:0] cwp, active;
  logic [NW-1:0] wim;
  logic [CN-1:0] ovf_count, unf_count;

  regwin_file #(.NWIN(NW), .XLEN(XL), .CNT_W(CN)) dut (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save(save), .restore(restore),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .cwp(cwp), .wim(wim), .active(active),
    .ovf_count(ovf_count), .unf_count(unf_count),
    .sb_en(sb_en), .sb_we(sb_we), .sb_idx(sb_idx),
    .sb_wdata(sb_wdata), .sb_rdata(sb_rdata),
    .spill_done(spill_done), .fill_done(fill_done)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // Behavioural model: globals, per-window locals and incoming groups.
  logic [XL-1:0] glob [8];
  bit            gk   [8];
  logic [XL-1:0] loc  [NW][8];
  bit            lk   [NW][8];
  logic [XL-1:0] inm  [NW][8];
  bit            ik   [NW][8];
  int m_cwp, m_wim, m_act, m_oc, m_uc;
  bit m_ovf, m_unf;
  logic [XL-1:0] ea, eb, esb;
  bit ka, kb, ksb;
  logic [XL-1:0] sbuf [16];

  function automatic int wdn(int w); return (w + NW - 1) % NW; endfunction
  function automatic int wup(int w); return (w + 1) % NW; endfunction

  task automatic mwr(int w, int r, logic [XL-1:0] v);
    if (r == 0) return;
    if (r < 8)       begin glob[r] = v; gk[r] = 1; end
    else if (r < 16) begin inm[wdn(w)][r-8] = v; ik[wdn(w)][r-8] = 1; end
    else if (r < 24) begin loc[w][r-16] = v; lk[w][r-16] = 1; end
    else             begin inm[w][r-24] = v; ik[w][r-24] = 1; end
  endtask

  task automatic mrd(int w, int r, output logic [XL-1:0] v, output bit k);
    if (r == 0)      begin v = '0; k = 1; end
    else if (r < 8)  begin v = glob[r]; k = gk[r]; end
    else if (r < 16) begin v = inm[wdn(w)][r-8]; k = ik[wdn(w)][r-8]; end
    else if (r < 24) begin v = loc[w][r-16]; k = lk[w][r-16]; end
    else             begin v = inm[w][r-24]; k = ik[w][r-24]; end
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    rd_a_addr = 0; rd_b_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    save = 0; restore = 0; sb_en = 0; sb_we = 0; sb_idx = 0; sb_wdata = 0;
    spill_done = 0; fill_done = 0;
  endtask

  // Advance one clock: update the model from the driven inputs, then compare.
  task automatic step();
    int nc, nw;
    if (rst) begin
      m_cwp = 0; m_wim = 1; m_act = 1; m_oc = 0; m_uc = 0;
      m_ovf = 0; m_unf = 0;
      ea = '0; eb = '0; esb = '0; ka = 1; kb = 1; ksb = 1;
    end else begin
      if (sb_en && sb_we) mwr(m_wim, 16 + int'(sb_idx), sb_wdata);
      else if (wr_en)     mwr(m_cwp, int'(wr_addr), wr_data);
      mrd(m_cwp, int'(rd_a_addr), ea, ka);
      mrd(m_cwp, int'(rd_b_addr), eb, kb);
      if (sb_en && !sb_we) mrd(wdn(m_wim), 16 + int'(sb_idx), esb, ksb);
      nc = m_cwp; m_ovf = 0; m_unf = 0;
      if (save) begin
        if (wdn(m_cwp) == m_wim) m_ovf = 1; else nc = wdn(m_cwp);
      end else if (restore) begin
        if (wup(m_cwp) == m_wim) m_unf = 1; else nc = wup(m_cwp);
      end
      nw = m_wim;
      if (spill_done && !fill_done && wdn(m_wim) != nc) nw = wdn(m_wim);
      else if (fill_done && !spill_done && wup(m_wim) != nc) nw = wup(m_wim);
      m_cwp = nc; m_wim = nw;
      m_act = (nw - nc + NW) % NW;
      if (m_ovf) m_oc++;
      if (m_unf) m_uc++;
    end
    @(posedge clk);
    #1;
    chk("R5 cwp", cwp, m_cwp);
    chk("R9 wim", wim, 64'(1) << m_wim);
    chk("R5 active", active, m_act);
    chk("R6 ovf_trap", ovf_trap, m_ovf);
    chk("R7 unf_trap", unf_trap, m_unf);
    chk("R6 ovf_count", ovf_count, m_oc);
    chk("R7 unf_count", unf_count, m_uc);
    if (ka)  chk("R2 rd_a_data", rd_a_data, ea);
    if (kb)  chk("R4 rd_b_data", rd_b_data, eb);
    if (ksb) chk("R12 sb_rdata", sb_rdata, esb);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin lk[w][i] = 0; ik[w][i] = 0; end
    for (int i = 0; i < 8; i++) gk[i] = 0;
    clr();
    rst = 1;
    #2;
    repeat (3) step();
    rst = 0;
    // R1: reset state
    chk("R1 cwp", cwp, 0);
    chk("R1 wim", wim, 8'h02);
    chk("R1 active", active, 1);
    chk("R1 counters", {ovf_count, unf_count}, 0);
    chk("R1 rd_a_data", rd_a_data, 0);

    // R2/R3: globals and register zero
    for (int i = 1; i < 8; i++) begin
      clr(); wr_en = 1; wr_addr = 5'(i); wr_data = 32'h100 + i; step();
    end
    clr(); wr_en = 1; wr_addr = 0; wr_data = 32'hDEAD; step();
    clr(); rd_a_addr = 0; rd_b_addr = 5; step();
    chk("R3 r0 reads zero after write", rd_a_data, 0);
    chk("R2 global r5", rd_b_data, 32'h105);

    // Outgoing and local groups of window 0
    for (int i = 0; i < 8; i++) begin
      clr(); wr_en = 1; wr_addr = 5'(8 + i); wr_data = 32'h800 + i; step();
      clr(); wr_en = 1; wr_addr = 5'(16 + i); wr_data = 32'hA00 + i; step();
    end
    clr(); save = 1; step();
    clr(); rd_a_addr = 27; rd_b_addr = 5; step();
    chk("R2 callee in3 equals caller out3", rd_a_data, 32'h803);
    chk("R2 global seen in new window", rd_b_data, 32'h105);
    clr(); wr_en = 1; wr_addr = 16; wr_data = 32'hBEEF; step();
    clr(); restore = 1; step();
    clr(); rd_a_addr = 16; step();
    chk("R2 locals private", rd_a_data, 32'hA00);

    // R4: write-first bypass
    clr(); wr_en = 1; wr_addr = 20; wr_data = 32'h1234; rd_b_addr = 20; step();
    chk("R4 bypass", rd_b_data, 32'h1234);

    // R8: save wins over restore
    clr(); save = 1; restore = 1; step();
    chk("R8 save priority", cwp, 7);
    clr(); restore = 1; step();

    // R6: overflow after six saves
    repeat (6) begin clr(); save = 1; step(); end
    clr(); save = 1; step();
    chk("R6 overflow pulse", ovf_trap, 1);
    chk("R6 pointer held", cwp, 2);
    clr(); step();
    chk("R6 pulse one cycle", ovf_trap, 0);

    // R9: spill frame 0 through the sideband
    for (int i = 0; i < 16; i++) begin
      clr(); sb_en = 1; sb_idx = 4'(i); step();
      sbuf[i] = sb_rdata;
    end
    chk("R9 spill reads local 3 of frame 0", sbuf[3], 32'hA03);
    clr(); step();
    chk("R12 sb_rdata held", sb_rdata, sbuf[15]);
    clr(); spill_done = 1; step();
    chk("R9 mark moved down", wim, 8'h01);
    chk("R9 active after spill", active, 6);
    clr(); save = 1; step();
    chk("R6 retried save", cwp, 1);

    // R7: underflow
    repeat (6) begin clr(); restore = 1; step(); end
    clr(); restore = 1; step();
    chk("R7 underflow pulse", unf_trap, 1);
    chk("R7 pointer held", cwp, 7);
    clr(); spill_done = 1; step();
    chk("R9 spill refused at one resident", wim, 8'h01);

    // R10: fill frame 0 back
    for (int i = 0; i < 16; i++) begin
      clr(); sb_en = 1; sb_we = 1; sb_idx = 4'(i); sb_wdata = sbuf[i]; step();
    end
    clr(); spill_done = 1; fill_done = 1; step();
    chk("R10 simultaneous done ignored", wim, 8'h01);
    clr(); fill_done = 1; step();
    chk("R10 mark moved up", wim, 8'h02);
    chk("R10 active after fill", active, 2);
    clr(); restore = 1; step();
    clr(); rd_a_addr = 19; step();
    chk("R10 filled local visible", rd_a_data, 32'hA03);

    // R11: sideband write drops a coincident core write
    clr(); wr_en = 1; wr_addr = 9; wr_data = 32'h55; step();
    clr(); sb_en = 1; sb_we = 1; sb_idx = 0; sb_wdata = 32'h77;
    wr_en = 1; wr_addr = 9; wr_data = 32'h66; step();
    clr(); rd_a_addr = 9; step();
    chk("R11 core write dropped", rd_a_data, 32'h55);

    // R10: fill refused when the ring is full
    repeat (6) begin clr(); save = 1; step(); end
    clr(); fill_done = 1; step();
    chk("R10 fill refused at full ring", wim, 8'h02);
    repeat (6) begin clr(); restore = 1; step(); end

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int sel;
      clr();
      rd_a_addr = 5'($urandom_range(0, 31));
      rd_b_addr = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) begin
        wr_en = 1; wr_addr = 5'($urandom_range(0, 31)); wr_data = $urandom;
      end
      sel = $urandom_range(0, 19);
      if (sel < 3) save = 1;
      else if (sel < 6) restore = 1;
      else if (sel == 6) begin save = 1; restore = 1; end
      else if (sel == 7) spill_done = 1;
      else if (sel == 8) fill_done = 1;
      else if (sel == 9) begin spill_done = 1; fill_done = 1; end
      if ($urandom_range(0, 3) == 0) begin
        sb_en = 1; sb_we = 1'($urandom_range(0, 1));
        sb_idx = 4'($urandom_range(0, 15)); sb_wdata = $urandom;
      end
      step();
    end
    finish_run();
  end

endmodule